// File: doc/BRIEF.md
# Serial Flash Page Read Sequencer

This block is the host-side master for reading a paged serial flash over a four-wire SPI bus. A requester hands it a page number, a starting byte offset inside that page and a byte count. The block then pulls chip select low and sends a 32-bit command word. The word holds an 8-bit read opcode, one reserved bit driven low, a 13-bit page number and a 10-bit byte offset. A run of don't-care clocks follows. After that the block collects the requested number of bytes from the serial input and hands each one out on a valid/ready byte port.

The serial clock is made inside the block by dividing the system clock. The bus idles with the clock low (SPI mode 0). The block drives its output bits while the clock is low, and the flash samples them on the rising edge. A received bit is taken during the high phase, which is the same as a rising-edge capture. If the byte port is full and not being drained, the block holds the serial clock low before the next byte starts, so no data is lost. A request whose offset lies past the end of a 528-byte page, or that asks for zero bytes, is refused at once with a one-cycle error pulse and never reaches the bus.

Top module: `spi_page_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `req_ready` is high, and `rd_valid` and `req_err` are low. The serial clock is low whenever chip select is high.
- R2: After chip select falls, the first 32 bits on `spi_mosi` are the opcode, then one reserved 0 bit, then the 13-bit page number, then the 10-bit offset. Every field goes out most significant bit first, and each bit is sampled by the flash on a rising serial clock edge.
- R3: Exactly `DUMMY_CLKS` (32) rising clock edges follow the 32 command bits before the first data bit. `spi_mosi` stays 0 from the end of the command word until chip select rises.
- R4: Data bits are taken from `spi_miso` one per clock, most significant bit first. Each completed byte appears on `rd_data` with `rd_valid` high.
- R5: A transaction delivers exactly `req_count` bytes and has exactly 64 + 8·`req_count` rising clock edges. Chip select rises one half-period after the last falling clock edge.
- R6: A request with an offset of 528 or more, or with a count of 0, raises `req_err` for exactly one cycle. Chip select stays high and no serial clock is produced.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` does not change. The serial clock does not begin a new byte until the held byte is taken.
- R8: Each serial clock half-period, and the time from chip select falling to the first rising edge, lasts `HALF_DIV` system clocks. The serial clock is low whenever chip select changes.
- R9: `req_ready` is low for the whole time chip select is low. A request presented during that time is ignored and does not change the bits sent on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle; a request is taken when both are high |
| req_page | input | 13 | Page number to read |
| req_offset | input | 10 | Starting byte offset inside the page |
| req_count | input | CNT_W | Number of bytes to read |
| req_err | output | 1 | One-cycle pulse: request refused |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer takes the byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with `HALF_DIV` = 2, the full 32 dummy clocks and a 16-bit count. A transaction of a few bytes then takes only a few hundred cycles, so one run covers many reads, including the last page with the last offset. The short half-period also makes any change to the clock spacing, the chip-select setup or the hold time show up directly in the measured intervals. A periodic `rd_ready` pattern forces repeated stalls between bytes, which exercises the clock hold at byte boundaries.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int PAGE_W = 13;
    localparam int OFFS_W = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_HOLD
    } spr_state_e;

    typedef struct packed {
        logic [7:0]        opcode;
        logic              rsvd;
        logic [PAGE_W-1:0] page;
        logic [OFFS_W-1:0] offs;
    } spr_cmd_t;

    localparam int CMD_BITS = $bits(spr_cmd_t);

    function automatic spr_cmd_t make_cmd(input logic [7:0] op,
                                          input logic [PAGE_W-1:0] pg,
                                          input logic [OFFS_W-1:0] off);
        spr_cmd_t c;
        c.opcode = op;
        c.rsvd   = 1'b0;
        c.page   = pg;
        c.offs   = off;
        return c;
    endfunction

endpackage

// File: rtl/spr_tick.sv
module spr_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [W-1:0] RELOAD = W'(HALF_DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= RELOAD;
        end else if (en) begin
            cnt <= (cnt == '0) ? RELOAD : cnt - 1'b1;
        end
    end

    assign tick = en && (cnt == '0);
endmodule

// File: rtl/spr_shift.sv
module spr_shift #(
    parameter int TX_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            tx_adv,
    input  logic            rx_cap,
    input  logic            miso,
    output logic            mosi,
    output logic [7:0]      rx_next
);
    logic [TX_W-1:0] tx_q;
    logic [7:0]      rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load) begin
                tx_q <= load_word;
            end else if (tx_adv) begin
                tx_q <= {tx_q[TX_W-2:0], 1'b0};
            end
            if (rx_cap) begin
                rx_q <= rx_next;
            end
        end
    end

    assign mosi    = tx_q[TX_W-1];
    assign rx_next = {rx_q[6:0], miso};
endmodule

// File: rtl/spi_page_reader.sv
module spi_page_reader
    import spr_pkg::*;
#(
    parameter int         HALF_DIV   = 4,
    parameter int         PAGE_BYTES = 528,
    parameter int         DUMMY_CLKS = 32,
    parameter int         CNT_W      = 16,
    parameter logic [7:0] OPCODE     = 8'hD2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [12:0]       req_page,
    input  logic [9:0]        req_offset,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_err,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int HDR_BITS = CMD_BITS + DUMMY_CLKS;
    localparam int HCNT_W   = $clog2(HDR_BITS + 1);
    localparam logic [OFFS_W:0] OFFS_LIM = (OFFS_W + 1)'(PAGE_BYTES);

    spr_state_e        state;
    logic              sck_q, cs_n_q, err_q, out_valid;
    logic [7:0]        out_data;
    logic [HCNT_W-1:0] hcnt;
    logic [2:0]        bcnt;
    logic [CNT_W-1:0]  remain;

    logic       accept, bad_req, start, pop, slot_free, tick;
    logic       tx_adv, rx_cap;
    logic [7:0] rx_next;
    spr_cmd_t   cmd;

    assign accept    = req_valid && (state == ST_IDLE);
    assign bad_req   = ({1'b0, req_offset} >= OFFS_LIM) || (req_count == '0);
    assign start     = accept && !bad_req;
    assign pop       = out_valid && rd_ready;
    assign slot_free = !out_valid || rd_ready;
    assign tx_adv    = (state == ST_HDR)  && tick && sck_q;
    assign rx_cap    = (state == ST_DATA) && tick && sck_q;
    assign cmd       = make_cmd(OPCODE, req_page, req_offset);

    spr_tick #(.HALF_DIV(HALF_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .en   (state != ST_IDLE),
        .tick (tick)
    );

    spr_shift #(.TX_W(CMD_BITS)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_word (cmd),
        .tx_adv    (tx_adv),
        .rx_cap    (rx_cap),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rx_next   (rx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sck_q     <= 1'b0;
            cs_n_q    <= 1'b1;
            err_q     <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            hcnt      <= '0;
            bcnt      <= '0;
            remain    <= '0;
        end else begin
            err_q <= accept && bad_req;
            if (pop) begin
                out_valid <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cs_n_q <= 1'b0;
                        hcnt   <= HCNT_W'(HDR_BITS);
                        bcnt   <= '0;
                        remain <= req_count;
                        state  <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                        end else begin
                            sck_q <= 1'b0;
                            hcnt  <= hcnt - 1'b1;
                            if (hcnt == HCNT_W'(1)) begin
                                state <= ST_DATA;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (!sck_q) begin
                            if (bcnt != '0 || slot_free) begin
                                sck_q <= 1'b1;
                            end
                        end else begin
                            sck_q <= 1'b0;
                            bcnt  <= bcnt + 3'd1;
                            if (bcnt == 3'd7) begin
                                out_data  <= rx_next;
                                out_valid <= 1'b1;
                                remain    <= remain - 1'b1;
                                if (remain == CNT_W'(1)) begin
                                    state <= ST_HOLD;
                                end
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        cs_n_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign req_err   = err_q;
    assign rd_data   = out_data;
    assign rd_valid  = out_valid;
    assign spi_cs_n  = cs_n_q;
    assign spi_sck   = sck_q;
endmodule

// File: rtl/spr_checker.sv
module spr_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       req_err,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       spi_cs_n,
    input logic       spi_sck
);
    // R1: no clock while deselected
    a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R8: chip select only moves while the clock is low
    a_r8_cs_edge_sck_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(spi_cs_n) || $fell(spi_cs_n)) |-> !spi_sck);

    // R7: held byte stays put under backpressure
    a_r7_hold_byte: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R6: refused request leaves the bus quiet
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (spi_cs_n && req_ready));

    // R9: no new request while selected
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !req_ready);
endmodule

bind spi_page_reader spr_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .req_err   (req_err),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck)
);

// File: tb/spi_page_reader_tb.sv
module spi_page_reader_tb_top;
    localparam int  HALF   = 2;
    localparam int  CNT_W  = 16;
    localparam int  PBYTES = 528;
    localparam logic [7:0] OPC = 8'hD2;
    localparam time TCLK   = 8ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, rd_ready = 1'b1;
    logic [12:0] req_page = '0;
    logic [9:0]  req_offset = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic req_ready, req_err, rd_valid;
    logic [7:0] rd_data;
    logic spi_cs_n, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(TCLK/2) clk = ~clk;

    spi_page_reader #(.HALF_DIV(HALF), .PAGE_BYTES(PBYTES), .DUMMY_CLKS(32),
                      .CNT_W(CNT_W), .OPCODE(OPC)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_offset(req_offset), .req_count(req_count),
        .req_err(req_err), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] fdata(input int pg, input int a);
        return 8'((pg * 3) + (a * 5) + 1);
    endfunction

    // behavioural flash responder
    logic [31:0] hdr_cap;
    int  rcnt = 0, ncs = 0, mosi_bad = 0;
    time t_last = 0, t_fall = 0, t_rise = 0, min_h = 0, max_h = 0;

    always @(negedge spi_cs_n) begin
        rcnt = 0; hdr_cap = '0; mosi_bad = 0; ncs++;
        t_last = $time; min_h = 1s; max_h = 0;
    end
    always @(posedge spi_cs_n) t_rise = $time;

    always @(posedge spi_sck) if (!spi_cs_n) begin
        if ($time - t_last < min_h) min_h = $time - t_last;
        if ($time - t_last > max_h) max_h = $time - t_last;
        t_last = $time;
        if (rcnt < 32) hdr_cap = {hdr_cap[30:0], spi_mosi};
        else if (spi_mosi !== 1'b0) mosi_bad++;
        rcnt++;
    end

    always @(negedge spi_sck) if (!spi_cs_n) begin
        if ($time - t_last < min_h) min_h = $time - t_last;
        if ($time - t_last > max_h) max_h = $time - t_last;
        t_last = $time;
        t_fall = $time;
        if (rcnt >= 64) begin
            automatic int k   = rcnt - 64;
            automatic int adr = (int'(hdr_cap[9:0]) + k / 8) % PBYTES;
            automatic logic [7:0] b = fdata(int'(hdr_cap[22:10]), adr);
            spi_miso = b[7 - (k % 8)];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(rd_valid == 1'b0 && req_err == 1'b0, "R1", "rd_valid/req_err after reset",
              rd_valid + req_err, 0);
    endtask

    task automatic do_read(input int pg, input int off, input int n,
                           input bit stall, input bit poke);
        int got = 0, cyc = 0, ncs0;
        bit hv = 0;
        logic [7:0] held = '0;
        logic [31:0] exp_hdr;
        ncs0 = ncs;
        exp_hdr = {OPC, 1'b0, 13'(pg), 10'(off)};
        @(negedge clk);
        req_valid = 1'b1; req_page = 13'(pg); req_offset = 10'(off);
        req_count = CNT_W'(n);
        @(negedge clk);
        req_valid = 1'b0;
        check(spi_cs_n == 1'b0, "R2", "cs_n low after accept", spi_cs_n, 0);
        check(req_ready == 1'b0, "R9", "req_ready while busy", req_ready, 0);
        if (poke) begin
            req_valid = 1'b1; req_page = ~13'(pg); req_offset = 10'd3;
            req_count = CNT_W'(1);
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                check(req_ready == 1'b0, "R9", "ready during poke", req_ready, 0);
            end
            req_valid = 1'b0;
        end
        while (got < n && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (hv) begin
                check(rd_valid == 1'b1 && rd_data == held, "R7", "held byte",
                      rd_data, held);
                hv = 0;
            end
            rd_ready = stall ? (cyc % 3 == 0) : 1'b1;
            if (rd_valid) begin
                if (rd_ready) begin
                    check(rd_data == fdata(pg, (off + got) % PBYTES), "R4", "data byte",
                          rd_data, fdata(pg, (off + got) % PBYTES));
                    got++;
                end else begin
                    held = rd_data; hv = 1;
                end
            end
        end
        rd_ready = 1'b1;
        check(got == n, "R5", "bytes delivered", got, n);
        while (!spi_cs_n && cyc < 40000) begin @(negedge clk); cyc++; end
        @(negedge clk);
        check(hdr_cap == exp_hdr, "R2", "command word", hdr_cap, exp_hdr);
        check(mosi_bad == 0, "R3", "mosi nonzero after command", mosi_bad, 0);
        check(rcnt == 64 + 8 * n, "R5", "rising edges", rcnt, 64 + 8 * n);
        check(t_rise - t_fall == HALF * TCLK, "R5", "cs hold ns",
              (t_rise - t_fall) / 1ns, HALF * TCLK / 1ns);
        check(ncs == ncs0 + 1, "R9", "one transaction", ncs - ncs0, 1);
        check(rd_valid == 1'b0 && req_ready == 1'b1, "R5", "no extra byte, idle",
              rd_valid, 0);
        check(min_h == HALF * TCLK, "R8", "min half period ns", min_h / 1ns,
              HALF * TCLK / 1ns);
        if (!stall)
            check(max_h == HALF * TCLK, "R8", "max half period ns", max_h / 1ns,
                  HALF * TCLK / 1ns);
    endtask

    task automatic do_reject(input int off, input int n);
        int ncs0 = ncs;
        @(negedge clk);
        req_valid = 1'b1; req_page = 13'd77; req_offset = 10'(off);
        req_count = CNT_W'(n);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b1, "R6", "req_err pulse", req_err, 1);
        @(negedge clk);
        check(req_err == 1'b0, "R6", "req_err one cycle", req_err, 0);
        for (int i = 0; i < 30; i++) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && ncs == ncs0, "R6",
              "bus quiet after refusal", ncs - ncs0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        test_reset();
        do_read(5, 0, 4, 0, 0);
        do_read(8191, 527, 3, 0, 0);
        do_read(4660, 300, 6, 1, 0);
        do_read(1, 100, 2, 0, 1);
        do_reject(528, 2);
        do_reject(1023, 1);
        do_reject(10, 0);
        do_read(4096, 525, 5, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule